// File: doc/BRIEF.md
# Binary XNOR-Popcount Neuron with Folded Normalisation

This block evaluates one binary neuron per clock for the hidden convolutional and dense layers of a binarised network. Each beat carries an input activation vector and a matching weight vector, both of length K and both holding only the values +1 and -1. The block forms their signed dot product with XNOR gates and a registered population-count tree. It then applies a per-channel normalisation that has been folded down to a signed offset and a single scale-sign bit, and binarises the result to one output bit.

The caller places the window or the flattened feature vector on `act_i`, the channel's weights on `wgt_i` and the channel's offset and scale sign on `ofs_i` and `neg_scale_i`, and raises `valid_i`. A new beat can be issued every cycle. The result appears on `act_o` with `valid_o` a fixed number of cycles later. The offset and the sign travel down the pipeline with their own beat.

Top module: `bnn_neuron`

## Requirements
- R1: While reset is held, and after it is released with no beat issued, `valid_o` and `act_o` are 0.
- R2: The sampling edge of a beat with `valid_i` high is edge 1. Its result is presented on `valid_o`/`act_o` right after edge LAT = clog2(K)+2, which is 9 for the default K=72. `valid_o` is high for exactly one cycle per issued beat.
- R3: Bit value 1 encodes +1 and bit value 0 encodes -1. The dot product is 2·popcount(XNOR(act_i, wgt_i)) − K.
- R4: With `neg_scale_i`=0, `act_o` is 1 exactly when dot + `ofs_i` ≥ 0. `ofs_i` is a two's-complement value.
- R5: With `neg_scale_i`=1, `act_o` is 1 exactly when dot + `ofs_i` < 0, or when the sum is 0.
- R6: A sum of exactly zero gives `act_o`=1 for either scale sign.
- R7: `ofs_i` and `neg_scale_i` are taken from the same cycle as the beat's vectors. Consecutive beats with different parameters are each evaluated with their own.
- R8: The extreme sums do not overflow: dot=+K with the most negative offset, and dot=−K with the most positive offset.
- R9: In cycles where `valid_o` is 0, `act_o` keeps the value of the last result.
- R10: Beats issued on consecutive cycles produce results on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat present on the inputs |
| act_i | input | VEC_LEN | Binary input activations (1 = +1) |
| wgt_i | input | VEC_LEN | Binary weights (1 = +1) |
| ofs_i | input | OFS_W | Signed normalisation offset |
| neg_scale_i | input | 1 | Scale sign, 1 = negative |
| valid_o | output | 1 | Result present |
| act_o | output | 1 | Binarised activation (1 = +1) |

## Verification
The bench aims at the zero-sum boundary under both scale signs. A design that applies a plain inversion for a negative scale returns 0 there, and a design that uses a strict comparison returns 0 for the positive scale. It drives full agreement against the most negative offset and full disagreement against the most positive offset. An adder that is too narrow wraps at these points and flips the output bit. Bursts in which the offset and the sign change on every beat expose side-band registers that are out of step with the data pipeline, because the results then come out with a neighbour's parameters. Every cycle is compared for timing, so an extra or missing register, or a result bit that moves in an idle cycle, is flagged at once.

// File: rtl/bnn_neuron_pkg.sv
package bnn_neuron_pkg;
  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // width of dot+offset with headroom for sign and carry
  function automatic int sum_width(input int k, input int ofs_w);
    return max_i($clog2(k + 1), ofs_w) + 2;
  endfunction
endpackage

// File: rtl/bnn_xnor_stage.sv
module bnn_xnor_stage #(
  parameter int K = 72
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [K-1:0] act_i,
  input  logic [K-1:0] wgt_i,
  output logic         valid_o,
  output logic [K-1:0] match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      match_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) match_o <= ~(act_i ^ wgt_i);
    end
  end
endmodule

// File: rtl/bnn_popcount_tree.sv
module bnn_popcount_tree #(
  parameter int K = 72,
  localparam int LVLS = $clog2(K),
  localparam int LEAVES = 1 << LVLS,
  localparam int CW = $clog2(K + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [K-1:0]  bits_i,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  logic [LEAVES-1:0] pad_w;
  assign pad_w = LEAVES'(bits_i);

  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    localparam int IN_CNT  = LEAVES >> lv;
    localparam int OUT_CNT = IN_CNT / 2;
    logic [CW*IN_CNT-1:0]  in_w;
    logic                  in_v;
    logic [CW*OUT_CNT-1:0] sum_q;
    logic                  v_q;

    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < IN_CNT; i++) begin : g_pad
        assign in_w[i*CW +: CW] = {{(CW-1){1'b0}}, pad_w[i]};
      end
      assign in_v = valid_i;
    end else begin : g_inner
      assign in_w = g_lvl[lv-1].sum_q;
      assign in_v = g_lvl[lv-1].v_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        sum_q <= '0;
      end else begin
        v_q <= in_v;
        if (in_v) begin
          for (int j = 0; j < OUT_CNT; j++)
            sum_q[j*CW +: CW] <= in_w[2*j*CW +: CW] + in_w[(2*j+1)*CW +: CW];
        end
      end
    end
  end

  assign count_o = g_lvl[LVLS-1].sum_q;
  assign valid_o = g_lvl[LVLS-1].v_q;
endmodule

// File: rtl/bnn_norm_act.sv
module bnn_norm_act #(
  parameter int K = 72,
  parameter int OFS_W = 8,
  localparam int CW = $clog2(K + 1),
  localparam int SW = bnn_neuron_pkg::sum_width(K, OFS_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [CW-1:0]        count_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  input  logic                 neg_i,
  output logic signed [SW-1:0] sum_o,
  output logic                 valid_o,
  output logic                 act_o
);
  logic signed [SW-1:0] dot_w;
  logic                 bit_w;

  assign dot_w = signed'(SW'({count_i, 1'b0})) - signed'(SW'(K));
  assign sum_o = dot_w + SW'(ofs_i);

  // zero maps to +1; otherwise the sign, flipped by a negative scale
  always_comb begin
    if (sum_o == '0) bit_w = 1'b1;
    else             bit_w = (sum_o > 0) ^ neg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      act_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) act_o <= bit_w;
    end
  end
endmodule

// File: rtl/bnn_neuron.sv
module bnn_neuron #(
  parameter int VEC_LEN = 72,
  parameter int OFS_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [VEC_LEN-1:0]      act_i,
  input  logic [VEC_LEN-1:0]      wgt_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  input  logic                    neg_scale_i,
  output logic                    valid_o,
  output logic                    act_o
);
  localparam int LVLS  = $clog2(VEC_LEN);
  localparam int CW    = $clog2(VEC_LEN + 1);
  localparam int SW    = bnn_neuron_pkg::sum_width(VEC_LEN, OFS_W);
  localparam int SIDE_D = LVLS + 1;
  localparam int LAT   = LVLS + 2;

  logic               x_valid;
  logic [VEC_LEN-1:0] x_match;
  logic               tree_valid;
  logic [CW-1:0]      pop_w;
  logic signed [SW-1:0] sum_w;

  // offset and scale sign follow their beat through xnor + tree stages
  logic [OFS_W:0] side_q [SIDE_D];
  logic signed [OFS_W-1:0] ofs_d;
  logic                    neg_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SIDE_D; i++) side_q[i] <= '0;
    end else begin
      side_q[0] <= {neg_scale_i, ofs_i};
      for (int i = 1; i < SIDE_D; i++) side_q[i] <= side_q[i-1];
    end
  end

  assign ofs_d = signed'(side_q[SIDE_D-1][OFS_W-1:0]);
  assign neg_d = side_q[SIDE_D-1][OFS_W];

  bnn_xnor_stage #(.K(VEC_LEN)) u_xnor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .act_i  (act_i),
    .wgt_i  (wgt_i),
    .valid_o(x_valid),
    .match_o(x_match)
  );

  bnn_popcount_tree #(.K(VEC_LEN)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(x_valid),
    .bits_i (x_match),
    .valid_o(tree_valid),
    .count_o(pop_w)
  );

  bnn_norm_act #(.K(VEC_LEN), .OFS_W(OFS_W)) u_norm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tree_valid),
    .count_i(pop_w),
    .ofs_i  (ofs_d),
    .neg_i  (neg_d),
    .sum_o  (sum_w),
    .valid_o(valid_o),
    .act_o  (act_o)
  );
endmodule

// File: rtl/bnn_neuron_chk.sv
module bnn_neuron_chk #(
  parameter int K = 72,
  parameter int CW = 7,
  parameter int SW = 10,
  parameter int LAT = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 valid_o,
  input logic                 act_o,
  input logic                 norm_v_i,
  input logic [CW-1:0]        count_i,
  input logic signed [SW-1:0] sum_i,
  input logic                 neg_i
);
  logic [31:0] inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + 32'(valid_i) - 32'(valid_o);
  end

  // R2
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 32'(LAT));

  // R2
  out_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> inflight_q != '0);

  // R3
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_v_i |-> int'(count_i) <= K);

  // R6
  zero_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_v_i && sum_i == '0) |=> (valid_o && act_o));

  // R4
  pos_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_v_i && !neg_i && sum_i < 0) |=> !act_o);

  // R5
  neg_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_v_i && neg_i && sum_i > 0) |=> !act_o);

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !norm_v_i |=> $stable(act_o));
endmodule

bind bnn_neuron bnn_neuron_chk #(
  .K  (VEC_LEN),
  .CW (CW),
  .SW (SW),
  .LAT(LAT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .act_o   (act_o),
  .norm_v_i(tree_valid),
  .count_i (pop_w),
  .sum_i   (sum_w),
  .neg_i   (neg_d)
);

// File: tb/tb_bnn_neuron.sv
module tb_bnn_neuron;
  localparam int CLK_PERIOD = 10;
  localparam int K = 72;
  localparam int OFS_W = 8;
  localparam int LAT = $clog2(K) + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [K-1:0] act_i = '0;
  logic [K-1:0] wgt_i = '0;
  logic signed [OFS_W-1:0] ofs_i = '0;
  logic neg_scale_i = 1'b0;
  logic valid_o, act_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnn_neuron #(.VEC_LEN(K), .OFS_W(OFS_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .act_i(act_i),
    .wgt_i(wgt_i), .ofs_i(ofs_i), .neg_scale_i(neg_scale_i),
    .valid_o(valid_o), .act_o(act_o)
  );

  typedef struct {
    int    due;
    bit    act;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit last_act = 1'b0;
  bit done = 1'b0;

  function automatic bit ref_act(input logic [K-1:0] a, input logic [K-1:0] w,
                                 input int ofs, input bit neg);
    int pc = 0;
    int s;
    for (int i = 0; i < K; i++) if (a[i] == w[i]) pc++;
    s = 2 * pc - K + ofs;
    if (s == 0) return 1'b1;
    return (s > 0) ? !neg : neg;
  endfunction

  task automatic send(input logic [K-1:0] a, input logic [K-1:0] w,
                      input int ofs, input bit neg, input string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; act_i = a; wgt_i = w;
    ofs_i = OFS_W'(ofs); neg_scale_i = neg;
    e.due = cyc + LAT;
    e.act = ref_act(a, w, ofs, neg);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      act_i = K'({$urandom, $urandom, $urandom});
      ofs_i = OFS_W'($urandom);
      neg_scale_i = 1'($urandom);
    end
  endtask

  // first n entries agree, rest disagree
  function automatic logic [K-1:0] agree_mask(input int n);
    logic [K-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  // cycle monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (q.size() != 0 && q[0].due == cyc) begin
        n_tests++;
        if (valid_o !== 1'b1 || act_o !== q[0].act) begin
          n_fail++;
          $display("FAIL %s cyc=%0d valid_o=%b act_o=%b expected valid_o=1 act_o=%b",
                   q[0].tag, cyc, valid_o, act_o, q[0].act);
        end
        last_act = q[0].act;
        void'(q.pop_front());
      end else begin
        n_tests++;
        if (valid_o !== 1'b0 || act_o !== last_act) begin
          n_fail++;
          $display("FAIL %s cyc=%0d valid_o=%b act_o=%b expected valid_o=0 act_o=%b",
                   rst_ni ? "R9/R2" : "R1", cyc, valid_o, act_o, last_act);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired pending=%0d expected 0", q.size());
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [K-1:0] a, w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(3); // R1 idle after reset

    // R3/R4: isolated random beats, positive scale
    for (int i = 0; i < 6; i++) begin
      a = K'({$urandom, $urandom, $urandom});
      w = K'({$urandom, $urandom, $urandom});
      send(a, w, int'($signed(OFS_W'($urandom))), 1'b0, "R3/R4");
      idle(LAT + 1);
    end

    // R8: extremes
    a = K'({$urandom, $urandom, $urandom});
    send(a, a, -128, 1'b0, "R8");
    send(a, a, -128, 1'b1, "R8");
    send(a, ~a, 127, 1'b0, "R8");
    send(a, ~a, 127, 1'b1, "R8");
    send('1, '1, 0, 1'b1, "R8");
    idle(LAT + 2);

    // R6: zero sum, dot = 2*31-72 = -10, ofs = 10
    a = K'({$urandom, $urandom, $urandom});
    send(a, ~(a ^ agree_mask(31)), 10, 1'b0, "R6");
    send(a, ~(a ^ agree_mask(31)), 10, 1'b1, "R6");
    send(a, ~(a ^ agree_mask(36)), 0, 1'b1, "R6");
    // one either side of zero
    send(a, ~(a ^ agree_mask(30)), 10, 1'b0, "R4");
    send(a, ~(a ^ agree_mask(32)), 10, 1'b1, "R5");
    idle(LAT + 2);

    // R5: negative scale random
    for (int i = 0; i < 8; i++) begin
      a = K'({$urandom, $urandom, $urandom});
      w = K'({$urandom, $urandom, $urandom});
      send(a, w, int'($signed(OFS_W'($urandom))), 1'b1, "R5");
      idle(2);
    end
    idle(LAT);

    // R7/R10: back-to-back burst with changing parameters
    for (int i = 0; i < 200; i++) begin
      a = K'({$urandom, $urandom, $urandom});
      w = (i % 3 == 0) ? ~(a ^ agree_mask(int'($urandom % (K + 1))))
                       : K'({$urandom, $urandom, $urandom});
      send(a, w, int'($signed(OFS_W'($urandom))), 1'($urandom), "R7/R10");
    end
    idle(LAT + 4);

    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending results=%0d expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule